// File: doc/BRIEF.md
# Serial Converter Command and Readout Port

This block is the device end of a serial link to a data converter. The link is framed by an active-low chip select and timed by the host's serial clock. While the frame is open, the block samples its data input on rising clock edges. It discards leading zeros and treats the first one as a start bit. The next three input bits configure the conversion: input mode (single-ended or differential), channel or polarity select, and output order. These three bits appear on dedicated outputs so that the converter front end can use them.

Output bits change on falling clock edges. On the fourth falling edge after the start bit, the block takes the output and drives a null bit. At the same edge it captures the conversion word from a parallel port. The word then leaves most significant bit first. When least-significant-first order was requested, the word is sent back out again from bit 1 upward. After that the block drives zeros until chip select rises, so a host that clocks in any word length reads left-justified data padded with zeros.

The output enable is brought out separately from the data. The input and output can therefore share one wire: the host releases the line before the fourth falling edge after the start bit, and the block drives nothing before that edge. Raising chip select at any time releases the output and returns the block to waiting for a start bit.

Top module: `adc_serial_slave`

## Requirements
- R1: While chip select is high, or while it is low and no one has yet been sampled on the data input, the output enable is low and zeros on the data input are ignored.
- R2: The three rising-edge samples that follow the start bit set, in this order, the single/differential output, the odd/sign output and the MSB-first output. The new values are visible after the third of those edges.
- R3: The output enable stays low through the third falling edge after the start bit. On the fourth falling edge it rises and the data output is 0 (the null bit).
- R4: On falling edges 5 through 14 after the start bit, the data output carries the captured word from bit 9 down to bit 0.
- R5: The word is sampled from the parallel port on the null-bit edge. Changes to the port after that edge do not alter the bits shifted out.
- R6: With the MSB-first bit at 1, every falling edge after the one carrying bit 0 drives a 0 until chip select rises.
- R7: With the MSB-first bit at 0, falling edges 15 through 23 carry bits 1 up to 9 of the word, and every later edge drives a 0.
- R8: Chip select rising at any point drops the output enable. The next frame again waits for a fresh start bit and a fresh configuration.
- R9: Data-input values after the third configuration bit, including the block's own output fed back on a shared wire, change neither the configuration outputs nor the output stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low frame select; high acts as reset |
| din | input | 1 | Serial data from the host |
| result_i | input | RES_W | Parallel conversion word |
| dout | output | 1 | Serial data to the host |
| dout_oe | output | 1 | Drive enable for dout (low means high impedance) |
| cfg_sgl_o | output | 1 | Captured single/differential select |
| cfg_odd_o | output | 1 | Captured odd/sign select |
| cfg_msbf_o | output | 1 | Captured MSB-first select |

## Verification
The bench opens frames with a varying number of leading zeros. A design that counted from the chip-select edge rather than from the start bit would misplace the null bit and every bit after it. The parallel word is changed just after the null edge to catch a design that reads it live and shifts out a torn word. Frames in both output orders run long past the word, which exposes a missing LSB-first replay or a nonzero tail. Frames are aborted mid-word and before any start bit, and the shared-wire case feeds the output back into the input; a design that failed to ignore late input would reconfigure itself or restart in the middle of a frame.

// File: rtl/adc_serial_slave.sv
module adc_serial_slave #(
  parameter int RES_W = 10
) (
  input  logic             sclk,
  input  logic             cs_n,
  input  logic             din,
  input  logic [RES_W-1:0] result_i,
  output logic             dout,
  output logic             dout_oe,
  output logic             cfg_sgl_o,
  output logic             cfg_odd_o,
  output logic             cfg_msbf_o
);
  localparam int NULL_EDGE = 4;
  localparam int LAST_MSB  = NULL_EDGE + RES_W;
  localparam int LAST_LSB  = NULL_EDGE + 2*RES_W - 1;
  localparam int CNT_MAX   = LAST_LSB + 1;
  localparam int CW        = $clog2(CNT_MAX + 2);
  localparam logic [CW-1:0] E_NULL = CW'(NULL_EDGE);
  localparam logic [CW-1:0] E_MSB  = CW'(LAST_MSB);
  localparam logic [CW-1:0] E_LSB  = CW'(LAST_LSB);
  localparam logic [CW-1:0] E_MAX  = CW'(CNT_MAX);

  logic             started;
  logic [1:0]       rcnt;
  logic [CW-1:0]    fcnt;
  logic [RES_W-1:0] sh;
  wire  [CW-1:0]    fnext = fcnt + 1'b1;

  always_ff @(posedge sclk or posedge cs_n)
    if (cs_n) begin
      started    <= 1'b0;
      rcnt       <= 2'd0;
      cfg_sgl_o  <= 1'b0;
      cfg_odd_o  <= 1'b0;
      cfg_msbf_o <= 1'b0;
    end else if (!started) begin
      started <= din;
    end else if (rcnt != 2'd3) begin
      rcnt <= rcnt + 2'd1;
      case (rcnt)
        2'd0:    cfg_sgl_o  <= din;
        2'd1:    cfg_odd_o  <= din;
        default: cfg_msbf_o <= din;
      endcase
    end

  always_ff @(negedge sclk or posedge cs_n)
    if (cs_n) begin
      fcnt    <= '0;
      dout    <= 1'b0;
      dout_oe <= 1'b0;
      sh      <= '0;
    end else if (started) begin
      if (fcnt != E_MAX) fcnt <= fnext;
      if (fnext == E_NULL) begin
        dout_oe <= 1'b1;
        dout    <= 1'b0;
        sh      <= result_i;
      end else if (fnext > E_NULL && fnext <= E_MSB) begin
        dout <= sh[RES_W-1];
        sh   <= {sh[RES_W-2:0], sh[RES_W-1]};
      end else if (!cfg_msbf_o && fnext > E_MSB && fnext <= E_LSB) begin
        dout <= sh[1];
        sh   <= {sh[0], sh[RES_W-1:1]};
      end else begin
        dout <= 1'b0;
      end
    end

  AST_NO_EARLY_DRIVE: assert property (@(posedge sclk) disable iff (cs_n)
    (rcnt != 2'd3) |-> !dout_oe); // R3
  AST_NULL_LOW: assert property (@(posedge sclk) disable iff (cs_n)
    (fcnt == E_NULL) |-> (dout_oe && !dout)); // R3
  AST_OE_HOLD: assert property (@(posedge sclk) disable iff (cs_n)
    dout_oe |=> dout_oe); // R8
  AST_CFG_FROZEN: assert property (@(posedge sclk) disable iff (cs_n)
    (rcnt == 2'd3) |=> $stable({cfg_sgl_o, cfg_odd_o, cfg_msbf_o})); // R9
  AST_MSBF_TAIL: assert property (@(posedge sclk) disable iff (cs_n)
    (cfg_msbf_o && fcnt > E_MSB) |-> !dout); // R6
  AST_LSBF_TAIL: assert property (@(posedge sclk) disable iff (cs_n)
    (fcnt > E_LSB) |-> !dout); // R7
endmodule

// File: tb/tb_adc_serial_slave.sv
module tb_adc_serial_slave;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       cs_n = 1'b1;
  logic       din_drv = 1'b0;
  logic       shared = 1'b0;
  logic [9:0] result = '0;
  logic       dout, dout_oe, c_sgl, c_odd, c_msbf;
  wire        din = (shared && dout_oe) ? dout : din_drv;

  adc_serial_slave #(.RES_W(10)) dut (
    .sclk(clk), .cs_n(cs_n), .din(din), .result_i(result),
    .dout(dout), .dout_oe(dout_oe),
    .cfg_sgl_o(c_sgl), .cfg_odd_o(c_odd), .cfg_msbf_o(c_msbf));

  int checks = 0, fails = 0;
  bit mst = 0, m_sgl = 0, m_odd = 0, m_msbf = 0, changed = 0;
  int k = 0;
  logic [9:0] m_res = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (t=%0t)", req, what, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit e_oe, e_d;
    string tag;
    if (!mst) begin
      if (din) begin mst = 1; k = 0; end
    end else k++;
    if (mst && k == 1) m_sgl = din;
    if (mst && k == 2) m_odd = din;
    if (mst && k == 3) m_msbf = din;
    if (mst && k == 4) m_res = result;
    e_oe = mst && k >= 4;
    tag = !mst ? "R1" : "R3";
    chk(dout_oe == e_oe, tag, "output enable", dout_oe, e_oe);
    if (e_oe) begin
      e_d = 1'b0;
      tag = "R3";
      if (k >= 5 && k <= 14) begin e_d = m_res[14-k]; tag = changed ? "R5" : "R4"; end
      else if (k > 14 && !m_msbf && k <= 23) begin e_d = m_res[k-14]; tag = "R7"; end
      else if (k > 14) tag = m_msbf ? "R6" : "R7";
      chk(dout == e_d, tag, "data out", dout, e_d);
    end
    if (mst && k >= 3) begin
      tag = (k == 3) ? "R2" : "R9";
      chk({c_sgl, c_odd, c_msbf} == {m_sgl, m_odd, m_msbf}, tag, "config bits",
          {c_sgl, c_odd, c_msbf}, {m_sgl, m_odd, m_msbf});
    end
  endtask

  task automatic tick(input logic d);
    @(negedge clk); #1 din_drv = d;
    @(posedge clk); #1 model_step();
  endtask

  task automatic close_frame();
    @(negedge clk); #1 cs_n = 1'b1; din_drv = 1'b0;
    @(posedge clk); #1;
    chk(dout_oe == 1'b0, "R8", "enable after chip select high", dout_oe, 0);
    mst = 0; k = 0; changed = 0; shared = 0;
  endtask

  task automatic frame(input int pre, input bit s, input bit o, input bit m,
                       input logic [9:0] v, input int len, input bit chg, input bit sh);
    result = v; shared = sh; changed = 0;
    @(negedge clk); #1 cs_n = 1'b0;
    for (int i = 0; i < pre; i++) tick(1'b0);
    tick(1'b1); tick(s); tick(o); tick(m);
    for (int i = 0; i < len; i++) begin
      tick(i[0] ^ i[2] ^ 1'b1);
      if (chg && k == 5) begin result = ~v; changed = 1; end
    end
    close_frame();
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 3; i++) begin
      @(posedge clk); #1 chk(dout_oe == 1'b0, "R1", "enable in reset", dout_oe, 0);
    end
    frame(3, 1, 0, 1, 10'h2A5, 20, 0, 0);
    frame(0, 0, 1, 0, 10'h3C1, 26, 1, 0);
    frame(5, 1, 1, 1, 10'h155, 16, 1, 1);
    frame(2, 0, 0, 0, 10'h2AA, 30, 0, 1);
    frame(1, 1, 0, 1, 10'h3FF, 3, 0, 0);
    frame(0, 1, 1, 0, 10'h001, 22, 0, 0);
    @(negedge clk); #1 cs_n = 1'b0;
    for (int i = 0; i < 6; i++) tick(1'b0);
    close_frame();
    frame(0, 1, 0, 1, 10'h200, 2, 0, 0);
    frame(4, 0, 1, 0, 10'h37B, 24, 1, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule